// File: doc/BRIEF.md
# Multi-Region Serial Configuration Chain

This block models the configuration memory of a programmable fabric. The bits are split into several independent serial chains, one per configuration region. Each region has its own serial input at the head and its own serial output at the tail. A region's contents and length are its own, but every region loads the same way: one bit per shift. The whole stored image is always visible on a parallel output, so downstream fabric logic can read it.

Shifting is driven by a vector of programming clock strobes. These strobes are qualifiers sampled on one fabric clock. Each region is assigned to exactly one strobe at elaboration time, so a group of regions that share a strobe advances together while the other regions hold. When the block is built with a single strobe, every region follows strobe 0 and any per-region assignment is ignored. A loader, for example a testbench, feeds a bitstream into each head. Per-region flags report whether a chain has received exactly its length in shifts, or more than that.

Top module: `cfgchain_multi_head`

## Requirements
- R1: A synchronous active-high `rst` clears every stored bit, every tail output, every full flag and every overrun flag to 0 at the next rising `clk` edge.
- R2: On a rising `clk` edge where region r's assigned strobe is 1, the bit on `head_in[r]` enters that region's cell 0 and every other cell k takes the old value of cell k-1.
- R3: When every bit of `prog_clk_en` is 0, `cfg_bits`, `tail_out`, `chain_full` and `chain_overrun` keep their values across the edge, whatever `head_in` does.
- R4: `tail_out[r]` is the region's last cell, so it shows the head bit that was shifted in LEN(r) shifts earlier.
- R5: Each region is assigned one strobe index, 4 bits per region in `CLK_MAP` with region 0 in the lowest field. A region shifts only when that strobe is 1. A strobe that is assigned to other regions leaves it unchanged.
- R6: All regions that share a strobe shift in the same cycle. With the map 0,0,0,1,2,2, strobe 0 moves regions 0 to 2, strobe 1 moves region 3, and strobe 2 moves regions 4 and 5.
- R7: When `NUM_CLOCKS` is 1, every region shifts on strobe 0, whatever values `CLK_MAP` holds.
- R8: `chain_full[r]` is 1 exactly when region r has shifted LEN(r) times since reset, and 0 before that.
- R9: A shift beyond LEN(r) clears `chain_full[r]` and sets `chain_overrun[r]`. The overrun flag then stays 1 until reset.
- R10: `cfg_bits` packs the regions in order, region 0 lowest. Region r starts at the sum of the lengths of all lower regions, and its cell 0 sits at the lowest bit of its field. Lengths are 8 bits per region in `CHAIN_LENS`, region 0 in the lowest field. A region's bits depend only on its own head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_clk_en | input | NUM_CLOCKS | Programming clock strobes, one per clock group |
| head_in | input | NUM_REGIONS | Serial data entering each region's chain |
| tail_out | output | NUM_REGIONS | Serial data leaving each region's chain |
| cfg_bits | output | sum of region lengths | Parallel image of all stored configuration bits |
| chain_full | output | NUM_REGIONS | Region has shifted exactly its length since reset |
| chain_overrun | output | NUM_REGIONS | Region has shifted more than its length since reset |

## Verification
The bench first applies each strobe on its own with head data toggling. A design that wires a region to the wrong strobe, or lets one strobe leak into another group, shows motion in a region that should hold. Chains of length 2 to 7 are filled until each passes its length. A counter that is off by one raises `chain_full` one shift early or late, and a non-sticky overrun drops back. The tail bit is compared after every shift, which exposes an inverted shift direction or a wrong cell offset in the parallel image. A second instance with a single strobe and a deliberately out-of-range map entry shows whether the single-clock variant really ignores the map.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;

    localparam int unsigned MAX_REGIONS = 16;
    localparam int unsigned LEN_W       = 8;
    localparam int unsigned SEL_W       = 4;
    localparam int unsigned LEN_TBL_W   = MAX_REGIONS * LEN_W;
    localparam int unsigned SEL_TBL_W   = MAX_REGIONS * SEL_W;

    typedef logic [LEN_TBL_W-1:0] len_tbl_t;
    typedef logic [SEL_TBL_W-1:0] sel_tbl_t;

    // Fill progress of one chain since reset.
    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PARTIAL,
        FILL_FULL,
        FILL_OVER
    } fill_e;

    typedef struct packed {
        logic full;
        logic overrun;
    } fill_flags_t;

    // Length of chain i taken from the packed length table.
    function automatic int unsigned chain_len(input len_tbl_t tbl, input int unsigned idx);
        return 32'(tbl[idx*LEN_W +: LEN_W]);
    endfunction

    // Bit offset of chain i inside the parallel image.
    function automatic int unsigned chain_off(input len_tbl_t tbl, input int unsigned idx);
        int unsigned sum;
        sum = 0;
        for (int unsigned j = 0; j < MAX_REGIONS; j++) begin
            if (j < idx) sum += chain_len(tbl, j);
        end
        return sum;
    endfunction

    // Total bits held by the first n chains.
    function automatic int unsigned chain_total(input len_tbl_t tbl, input int unsigned n);
        return chain_off(tbl, n);
    endfunction

    // Strobe index driving chain i; a single-strobe build ties all chains to 0.
    function automatic int unsigned head_clock(input sel_tbl_t tbl, input int unsigned idx,
                                               input int unsigned nclk);
        if (nclk <= 1) return 0;
        return 32'(tbl[idx*SEL_W +: SEL_W]);
    endfunction

endpackage

// File: rtl/cfgchain_clk_route.sv
module cfgchain_clk_route
    import cfgchain_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 1,
    parameter int unsigned NUM_CLOCKS  = 1,
    parameter sel_tbl_t    CLK_MAP     = '0
) (
    input  logic [NUM_CLOCKS-1:0]  prog_clk_en,
    output logic [NUM_REGIONS-1:0] region_en
);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_route
        localparam int unsigned SEL = head_clock(CLK_MAP, r, NUM_CLOCKS);
        if (SEL < NUM_CLOCKS) begin : g_valid
            assign region_en[r] = prog_clk_en[SEL];
        end else begin : g_unmapped
            assign region_en[r] = 1'b0;
        end
    end

endmodule

// File: rtl/cfgchain_region.sv
module cfgchain_region
    import cfgchain_pkg::*;
#(
    parameter int unsigned LEN = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           head_in,
    output logic [LEN-1:0] cells,
    output logic           tail_out,
    output fill_flags_t    flags
);

    localparam int unsigned CNT_W = $clog2(LEN + 1);

    fill_e            fill_q;
    logic [CNT_W-1:0] count_q;

    // Storage: cell 0 takes the head, the last cell is the tail.
    if (LEN == 1) begin : g_single
        always_ff @(posedge clk) begin
            if (rst)           cells <= '0;
            else if (shift_en) cells <= head_in;
        end
    end else begin : g_multi
        always_ff @(posedge clk) begin
            if (rst)           cells <= '0;
            else if (shift_en) cells <= {cells[LEN-2:0], head_in};
        end
    end

    assign tail_out = cells[LEN-1];

    // Shift accounting since reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q  <= FILL_EMPTY;
            count_q <= '0;
        end else if (shift_en) begin
            unique case (fill_q)
                FILL_EMPTY: begin
                    count_q <= CNT_W'(1);
                    fill_q  <= (LEN == 1) ? FILL_FULL : FILL_PARTIAL;
                end
                FILL_PARTIAL: begin
                    count_q <= count_q + CNT_W'(1);
                    if (count_q == CNT_W'(LEN - 1)) fill_q <= FILL_FULL;
                end
                FILL_FULL: fill_q <= FILL_OVER;
                FILL_OVER: fill_q <= FILL_OVER;
                default:   fill_q <= FILL_OVER;
            endcase
        end
    end

    always_comb begin
        flags.full    = (fill_q == FILL_FULL);
        flags.overrun = (fill_q == FILL_OVER);
    end

endmodule

// File: rtl/cfgchain_multi_head.sv
module cfgchain_multi_head
    import cfgchain_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 1,
    parameter int unsigned NUM_CLOCKS  = 1,
    parameter len_tbl_t    CHAIN_LENS  = len_tbl_t'(8),
    parameter sel_tbl_t    CLK_MAP     = '0
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic [NUM_CLOCKS-1:0]                           prog_clk_en,
    input  logic [NUM_REGIONS-1:0]                          head_in,
    output logic [NUM_REGIONS-1:0]                          tail_out,
    output logic [chain_total(CHAIN_LENS, NUM_REGIONS)-1:0] cfg_bits,
    output logic [NUM_REGIONS-1:0]                          chain_full,
    output logic [NUM_REGIONS-1:0]                          chain_overrun
);

    localparam int unsigned TOTAL_BITS = chain_total(CHAIN_LENS, NUM_REGIONS);

    logic [NUM_REGIONS-1:0] region_en;
    logic [TOTAL_BITS-1:0]  image;

    cfgchain_clk_route #(
        .NUM_REGIONS(NUM_REGIONS),
        .NUM_CLOCKS (NUM_CLOCKS),
        .CLK_MAP    (CLK_MAP)
    ) i_route (
        .prog_clk_en(prog_clk_en),
        .region_en  (region_en)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        localparam int unsigned LEN = chain_len(CHAIN_LENS, r);
        localparam int unsigned OFF = chain_off(CHAIN_LENS, r);

        fill_flags_t flags;

        cfgchain_region #(
            .LEN(LEN)
        ) i_region (
            .clk     (clk),
            .rst     (rst),
            .shift_en(region_en[r]),
            .head_in (head_in[r]),
            .cells   (image[OFF +: LEN]),
            .tail_out(tail_out[r]),
            .flags   (flags)
        );

        assign chain_full[r]    = flags.full;
        assign chain_overrun[r] = flags.overrun;
    end

    assign cfg_bits = image;

endmodule

// File: rtl/cfgchain_multi_head_chk.sv
module cfgchain_multi_head_chk
    import cfgchain_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 1,
    parameter int unsigned NUM_CLOCKS  = 1,
    parameter len_tbl_t    CHAIN_LENS  = len_tbl_t'(8),
    parameter sel_tbl_t    CLK_MAP     = '0
) (
    input logic                                            clk,
    input logic                                            rst,
    input logic [NUM_CLOCKS-1:0]                           prog_clk_en,
    input logic [NUM_REGIONS-1:0]                          head_in,
    input logic [NUM_REGIONS-1:0]                          tail_out,
    input logic [chain_total(CHAIN_LENS, NUM_REGIONS)-1:0] cfg_bits,
    input logic [NUM_REGIONS-1:0]                          chain_full,
    input logic [NUM_REGIONS-1:0]                          chain_overrun
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_bits == '0 && tail_out == '0 && chain_full == '0 && chain_overrun == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (prog_clk_en == '0) |=> ($stable(cfg_bits) && $stable(chain_full) && $stable(chain_overrun))); // R3

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg_chk
        localparam int unsigned LEN = chain_len(CHAIN_LENS, r);
        localparam int unsigned OFF = chain_off(CHAIN_LENS, r);
        localparam int unsigned SEL = head_clock(CLK_MAP, r, NUM_CLOCKS);

        if (SEL < NUM_CLOCKS) begin : g_mapped
            AST_HEAD_ENTERS: assert property (@(posedge clk) disable iff (rst)
                prog_clk_en[SEL] |=> (cfg_bits[OFF] == $past(head_in[r]))); // R2

            AST_OTHER_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
                !prog_clk_en[SEL] |=> $stable(cfg_bits[OFF +: LEN])); // R5

            AST_FULL_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (rst)
                $rose(chain_full[r]) |-> $past(prog_clk_en[SEL])); // R8

            if (LEN > 1) begin : g_tail
                AST_TAIL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
                    prog_clk_en[SEL] |=> (tail_out[r] == $past(cfg_bits[OFF + LEN - 2]))); // R4
            end
        end

        AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
            chain_overrun[r] |=> chain_overrun[r]); // R9

        AST_FULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
            $rose(chain_overrun[r]) |-> $past(chain_full[r])); // R9
    end

endmodule

bind cfgchain_multi_head cfgchain_multi_head_chk #(
    .NUM_REGIONS(NUM_REGIONS),
    .NUM_CLOCKS (NUM_CLOCKS),
    .CHAIN_LENS (CHAIN_LENS),
    .CLK_MAP    (CLK_MAP)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .prog_clk_en  (prog_clk_en),
    .head_in      (head_in),
    .tail_out     (tail_out),
    .cfg_bits     (cfg_bits),
    .chain_full   (chain_full),
    .chain_overrun(chain_overrun)
);

// File: tb/test_cfgchain_multi_head.sv
module test_cfgchain_multi_head;
    import cfgchain_pkg::*;

    localparam int NR = 6;
    localparam int NB = 2;
    localparam int LENS [NR] = '{5, 3, 7, 4, 6, 2};
    localparam int OFFS [NR] = '{0, 5, 8, 15, 19, 25};
    localparam int MAP  [NR] = '{0, 0, 0, 1, 2, 2};
    localparam int LENS_B [NB] = '{3, 2};
    localparam int OFFS_B [NB] = '{0, 3};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  prog_clk_en = '0;
    logic [5:0]  head_in = '0;
    logic [5:0]  tail_out, chain_full, chain_overrun;
    logic [26:0] cfg_bits;
    logic [1:0]  tail_b, full_b, over_b;
    logic [4:0]  cfg_b;

    always #2 clk = ~clk;  // 250 MHz

    cfgchain_multi_head #(
        .NUM_REGIONS(NR),
        .NUM_CLOCKS (3),
        .CHAIN_LENS (len_tbl_t'({8'd2, 8'd6, 8'd4, 8'd7, 8'd3, 8'd5})),
        .CLK_MAP    (sel_tbl_t'({4'd2, 4'd2, 4'd1, 4'd0, 4'd0, 4'd0}))
    ) i_cfgchain_multi_head (
        .clk(clk), .rst(rst), .prog_clk_en(prog_clk_en), .head_in(head_in),
        .tail_out(tail_out), .cfg_bits(cfg_bits),
        .chain_full(chain_full), .chain_overrun(chain_overrun)
    );

    // Single-strobe variant; region 1 carries an out-of-range map entry (R7).
    cfgchain_multi_head #(
        .NUM_REGIONS(NB),
        .NUM_CLOCKS (1),
        .CHAIN_LENS (len_tbl_t'({8'd2, 8'd3})),
        .CLK_MAP    (sel_tbl_t'({4'd3, 4'd0}))
    ) i_cfgchain_single (
        .clk(clk), .rst(rst), .prog_clk_en(prog_clk_en[0:0]), .head_in(head_in[1:0]),
        .tail_out(tail_b), .cfg_bits(cfg_b),
        .chain_full(full_b), .chain_overrun(over_b)
    );

    typedef struct {
        logic [5:0]  tail;
        logic [26:0] cfg;
        logic [5:0]  full;
        logic [5:0]  over;
        logic [1:0]  tail_b;
        logic [4:0]  cfg_b;
        logic [1:0]  full_b;
        logic [1:0]  over_b;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mdl   [NR][8];
    int   cnt   [NR];
    bit   mdl_b [NB][3];
    int   cnt_b [NB];
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic apply(input logic [2:0] en, input logic [5:0] head, input string tag,
                         input bit do_rst = 1'b0);
        exp_t e;
        @(negedge clk);
        rst         = do_rst;
        prog_clk_en = en;
        head_in     = head;
        for (int r = 0; r < NR; r++) begin
            if (do_rst) begin
                for (int k = 0; k < 8; k++) mdl[r][k] = 1'b0;
                cnt[r] = 0;
            end else if (en[MAP[r]]) begin
                for (int k = LENS[r] - 1; k > 0; k--) mdl[r][k] = mdl[r][k-1];
                mdl[r][0] = head[r];
                if (cnt[r] <= LENS[r]) cnt[r]++;
            end
        end
        for (int r = 0; r < NB; r++) begin
            if (do_rst) begin
                for (int k = 0; k < 3; k++) mdl_b[r][k] = 1'b0;
                cnt_b[r] = 0;
            end else if (en[0]) begin
                for (int k = LENS_B[r] - 1; k > 0; k--) mdl_b[r][k] = mdl_b[r][k-1];
                mdl_b[r][0] = head[r];
                if (cnt_b[r] <= LENS_B[r]) cnt_b[r]++;
            end
        end
        e.cfg = '0;
        for (int r = 0; r < NR; r++) begin
            for (int k = 0; k < LENS[r]; k++) e.cfg[OFFS[r] + k] = mdl[r][k];
            e.tail[r] = mdl[r][LENS[r] - 1];
            e.full[r] = (cnt[r] == LENS[r]);
            e.over[r] = (cnt[r] > LENS[r]);
        end
        e.cfg_b = '0;
        for (int r = 0; r < NB; r++) begin
            for (int k = 0; k < LENS_B[r]; k++) e.cfg_b[OFFS_B[r] + k] = mdl_b[r][k];
            e.tail_b[r] = mdl_b[r][LENS_B[r] - 1];
            e.full_b[r] = (cnt_b[r] == LENS_B[r]);
            e.over_b[r] = (cnt_b[r] > LENS_B[r]);
        end
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares one edge's result shortly after that edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            cur = q.pop_front();
            n_checks++;
            if (tail_out !== cur.tail || cfg_bits !== cur.cfg ||
                chain_full !== cur.full || chain_overrun !== cur.over) begin
                n_fail++;
                $display("FAIL %s: tail %b/%b cfg %h/%h full %b/%b over %b/%b (actual/expected)",
                         cur.tag, tail_out, cur.tail, cfg_bits, cur.cfg,
                         chain_full, cur.full, chain_overrun, cur.over);
            end
            n_checks++;
            if (tail_b !== cur.tail_b || cfg_b !== cur.cfg_b ||
                full_b !== cur.full_b || over_b !== cur.over_b) begin
                n_fail++;
                $display("FAIL R7 (%s): tail %b/%b cfg %h/%h full %b/%b over %b/%b (actual/expected)",
                         cur.tag, tail_b, cur.tail_b, cfg_b, cur.cfg_b,
                         full_b, cur.full_b, over_b, cur.over_b);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        apply(3'b000, 6'b000000, "R1 reset", 1'b1);
        apply(3'b000, 6'b111111, "R1 reset", 1'b1);
        // R3: heads toggle with no strobe
        apply(3'b000, 6'b111111, "R3 idle");
        apply(3'b000, 6'b010101, "R3 idle");
        apply(3'b000, 6'b101010, "R3 idle");
        // R5 R6: each strobe alone
        apply(3'b001, 6'b111111, "R5 R6 strobe0");
        apply(3'b001, 6'b010101, "R5 R6 strobe0");
        apply(3'b010, 6'b111111, "R5 strobe1");
        apply(3'b100, 6'b110000, "R5 R6 strobe2");
        apply(3'b000, 6'b111111, "R3 idle after shifts");
        // R8 R9: strobe 0 past region 1 length 3
        apply(3'b000, 6'b000000, "R1 reset", 1'b1);
        apply(3'b001, 6'b000111, "R8 fill");
        apply(3'b001, 6'b000010, "R8 fill");
        apply(3'b001, 6'b000101, "R8 region1 full");
        apply(3'b001, 6'b000011, "R9 region1 overrun");
        apply(3'b000, 6'b000000, "R9 sticky");
        apply(3'b001, 6'b000111, "R8 region0 full");
        apply(3'b001, 6'b000111, "R9 region0 overrun");
        // R1: reset clears overrun
        apply(3'b000, 6'b000000, "R1 reset clears overrun", 1'b1);
        apply(3'b000, 6'b000000, "R1 after reset");
        // R2 R4 R10: all strobes, pseudo-random heads
        for (int i = 0; i < 10; i++) begin
            lfsr = lfsr_next(lfsr);
            apply(3'b111, lfsr[5:0], "R2 R4 R8 R9 R10 all strobes");
        end
        // R4 R5 R6: random strobes and heads
        apply(3'b000, 6'b000000, "R1 reset", 1'b1);
        for (int i = 0; i < 40; i++) begin
            lfsr = lfsr_next(lfsr);
            apply(lfsr[8:6], lfsr[5:0], "R4 R5 R6 R10 mixed strobes");
        end
        apply(3'b000, 6'b000000, "R3 final idle");
        repeat (3) @(posedge clk);
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule